// File: doc/BRIEF.md
# Cycle-Masked Macrotick Match Timer

This block holds two timer channels that count on a communication-cycle time base. The protocol engine supplies the time base: a 6-bit cycle counter, a 14-bit macrotick counter and a one-cycle strobe that marks the start of each macrotick. Channel 1 is always absolute. It expires on a macrotick start when the masked cycle count equals its masked compare value and the macrotick count equals its programmed offset. Channel 2 works the same way in absolute mode. In relative mode it instead counts down a programmed number of macrotick starts.

Each channel has a start pulse, a stop pulse and a repeat option. On expiry a channel sets a sticky flag, which is cleared by a write-1 pulse. An interrupt line shows that flag when the channel's enable bit is 1. A running bit reports whether the channel is armed. The channels run only while the protocol-state input reports a normal operating state. Leaving such a state disarms both channels. Software must restart them after that.

Top module: `cycmatch_timer`

## Requirements
- R1: The channels may run only while `protoState` is 4 (normal active) or 5 (normal passive). Any other value clears `chRunning` of both channels at the next clock edge. Returning to 4 or 5 leaves them stopped, and no expiry occurs until a new start.
- R2: A start pulse given while `protoState` is not 4 or 5 is ignored. `chRunning` stays 0.
- R3: After reset all outputs are 0. A start pulse in a normal state sets `chRunning` one cycle later. A stop pulse clears it one cycle later. Stop wins over a start given in the same cycle.
- R4: An absolute channel expires only in a cycle with `mtStart` high where ((cycleCount XOR cycVal) AND cycMask) is 0 and `mtCount` equals its offset. Cycle-count bits with a 0 mask bit are not compared.
- R5: An expiry sets `chFlag` one cycle later. The flag stays set until a `chFlagClr` pulse clears it. If an expiry and a clear occur in the same cycle, the flag ends set.
- R6: `chIrq[c]` equals `chFlag[c]` AND `chIrqEn[c]` in the same cycle.
- R7: A channel without repeat clears `chRunning` on expiry. A repeating channel stays running and can expire again at its next match.
- R8: With `t2Relative` at 1, a start loads `t2Reload` into channel 2. Each later `mtStart` counts it down by one, so channel 2 expires on the N-th `mtStart` after a start with N = `t2Reload` (N = 0 expires on the first). In repeat mode it reloads on expiry.
- R9: With `t2Relative` at 0, channel 2 matches only on its own mask, value and offset. `t2Relative` has no effect on channel 1.
- R10: A start or stop pulse in a cycle where the channel would otherwise expire suppresses that expiry. No flag is set in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleCount | input | 6 | Communication cycle number |
| mtCount | input | 14 | Macrotick number within the cycle |
| mtStart | input | 1 | Macrotick-start strobe |
| protoState | input | 3 | Protocol state code (4, 5 = normal) |
| chStart | input | 2 | Start pulse per channel |
| chStop | input | 2 | Stop pulse per channel |
| chRepeat | input | 2 | Repeat mode per channel |
| chIrqEn | input | 2 | Interrupt enable per channel |
| chFlagClr | input | 2 | Write-1 flag clear per channel |
| chCycMask | input | 2x6 | Cycle-count compare mask per channel |
| chCycVal | input | 2x6 | Cycle-count compare value per channel |
| chMtOffset | input | 2x14 | Macrotick compare offset per channel |
| t2Relative | input | 1 | Channel 2 relative mode |
| t2Reload | input | 14 | Channel 2 relative macrotick count |
| chRunning | output | 2 | Channel armed status |
| chFlag | output | 2 | Sticky expiry flag |
| chIrq | output | 2 | Masked interrupt request |

## Verification
A wrong running bit shows at `chRunning` on the next cycle. It also shows later as a missing or extra `chFlag` at the next matching macrotick start. A corrupted relative count stays hidden until expiry, and then shows as a flag that rises on the wrong macrotick start. The bench therefore compares every output against a reference model after each clock edge, so a divergence is reported in the cycle in which it first becomes visible.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int NUM_CH = 2;
  localparam int REL_CH = 1;
  localparam int ST_W = 3;
  localparam logic [ST_W-1:0] ST_NORMAL_ACTIVE  = 3'd4;
  localparam logic [ST_W-1:0] ST_NORMAL_PASSIVE = 3'd5;

  typedef struct packed {
    logic load;
    logic dec;
  } chStrobe_t;
endpackage

// File: rtl/cmt_dpath.sv
module cmt_dpath
  import cmt_pkg::*;
#(
  parameter int CYC_W = 6,
  parameter int MT_W  = 14
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [CYC_W-1:0]                 cycleCount,
  input  logic [MT_W-1:0]                  mtCount,
  input  logic [NUM_CH-1:0][CYC_W-1:0]     cycMask,
  input  logic [NUM_CH-1:0][CYC_W-1:0]     cycVal,
  input  logic [NUM_CH-1:0][MT_W-1:0]      mtOffset,
  input  logic                             relMode,
  input  logic [MT_W-1:0]                  relReload,
  input  chStrobe_t [NUM_CH-1:0]           strobe,
  output logic [NUM_CH-1:0]                hit
);
  localparam logic [MT_W-1:0] ONE = MT_W'(1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic absHit;
    always_comb begin
      absHit = (((cycleCount ^ cycVal[c]) & cycMask[c]) == '0) &&
               (mtCount == mtOffset[c]);
    end

    if (c == REL_CH) begin : g_rel
      logic [MT_W-1:0] relCnt;
      logic relHit;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          relCnt <= '0;
        end else if (strobe[c].load) begin
          relCnt <= relReload;
        end else if (strobe[c].dec) begin
          relCnt <= relCnt - ONE;
        end
      end

      always_comb begin
        relHit = (relCnt <= ONE);
        hit[c] = relMode ? relHit : absHit;
      end

      assert_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
        strobe[c].load |=> relCnt == $past(relReload));
      assert_countdown_R8: assert property (@(posedge clk) disable iff (!rstN)
        (strobe[c].dec && !strobe[c].load) |=> relCnt == $past(relCnt) - ONE);
    end else begin : g_abs
      always_comb hit[c] = absHit;
    end
  end
endmodule

// File: rtl/cmt_ctrl.sv
module cmt_ctrl
  import cmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ST_W-1:0]      protoState,
  input  logic                 mtStart,
  input  logic [NUM_CH-1:0]    hit,
  input  logic [NUM_CH-1:0]    start,
  input  logic [NUM_CH-1:0]    stop,
  input  logic [NUM_CH-1:0]    repeatEn,
  input  logic [NUM_CH-1:0]    irqEn,
  input  logic [NUM_CH-1:0]    flagClr,
  output logic [NUM_CH-1:0]    running,
  output logic [NUM_CH-1:0]    flag,
  output logic [NUM_CH-1:0]    irq,
  output chStrobe_t [NUM_CH-1:0] strobe
);
  logic protoOk;
  logic [NUM_CH-1:0] expire;

  always_comb begin
    protoOk = (protoState == ST_NORMAL_ACTIVE) || (protoState == ST_NORMAL_PASSIVE);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic quiet;
    always_comb begin
      quiet = !start[c] && !stop[c];
      expire[c] = running[c] && protoOk && mtStart && hit[c] && quiet;
      strobe[c].load = protoOk && !stop[c] && (start[c] || (expire[c] && repeatEn[c]));
      strobe[c].dec  = running[c] && protoOk && mtStart && quiet;
      irq[c] = flag[c] && irqEn[c];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        running[c] <= 1'b0;
        flag[c]    <= 1'b0;
      end else begin
        flag[c] <= (flag[c] && !flagClr[c]) || expire[c];
        if (!protoOk || stop[c]) begin
          running[c] <= 1'b0;
        end else if (start[c]) begin
          running[c] <= 1'b1;
        end else if (expire[c] && !repeatEn[c]) begin
          running[c] <= 1'b0;
        end
      end
    end

    assert_stop_halts_R3: assert property (@(posedge clk) disable iff (!rstN)
      stop[c] |=> !running[c]);
    assert_start_arms_R3: assert property (@(posedge clk) disable iff (!rstN)
      (start[c] && !stop[c] && protoOk) |=> running[c]);
    assert_leave_normal_R1: assert property (@(posedge clk) disable iff (!rstN)
      !protoOk |=> !running[c]);
    assert_expiry_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
      expire[c] |=> flag[c]);
    assert_repeat_stays_R7: assert property (@(posedge clk) disable iff (!rstN)
      (expire[c] && repeatEn[c]) |=> running[c]);
  end
endmodule

// File: rtl/cycmatch_timer.sv
module cycmatch_timer
  import cmt_pkg::*;
#(
  parameter int CYC_W = 6,
  parameter int MT_W  = 14
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [CYC_W-1:0]              cycleCount,
  input  logic [MT_W-1:0]               mtCount,
  input  logic                          mtStart,
  input  logic [ST_W-1:0]               protoState,
  input  logic [NUM_CH-1:0]             chStart,
  input  logic [NUM_CH-1:0]             chStop,
  input  logic [NUM_CH-1:0]             chRepeat,
  input  logic [NUM_CH-1:0]             chIrqEn,
  input  logic [NUM_CH-1:0]             chFlagClr,
  input  logic [NUM_CH-1:0][CYC_W-1:0]  chCycMask,
  input  logic [NUM_CH-1:0][CYC_W-1:0]  chCycVal,
  input  logic [NUM_CH-1:0][MT_W-1:0]   chMtOffset,
  input  logic                          t2Relative,
  input  logic [MT_W-1:0]               t2Reload,
  output logic [NUM_CH-1:0]             chRunning,
  output logic [NUM_CH-1:0]             chFlag,
  output logic [NUM_CH-1:0]             chIrq
);
  chStrobe_t [NUM_CH-1:0] strobe;
  logic [NUM_CH-1:0] hit;

  cmt_dpath #(.CYC_W(CYC_W), .MT_W(MT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cycleCount(cycleCount), .mtCount(mtCount),
    .cycMask(chCycMask), .cycVal(chCycVal), .mtOffset(chMtOffset),
    .relMode(t2Relative), .relReload(t2Reload), .strobe(strobe), .hit(hit)
  );

  cmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .protoState(protoState), .mtStart(mtStart),
    .hit(hit), .start(chStart), .stop(chStop), .repeatEn(chRepeat),
    .irqEn(chIrqEn), .flagClr(chFlagClr), .running(chRunning),
    .flag(chFlag), .irq(chIrq), .strobe(strobe)
  );
endmodule

// File: tb/cycmatch_timer_bench.sv
module cycmatch_timer_bench;
  localparam int CYC_W = 6;
  localparam int MT_W  = 14;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN;
  logic [CYC_W-1:0] cycleCount;
  logic [MT_W-1:0] mtCount, t2Reload;
  logic mtStart, t2Relative;
  logic [2:0] protoState;
  logic [1:0] chStart, chStop, chRepeat, chIrqEn, chFlagClr;
  logic [1:0][CYC_W-1:0] chCycMask, chCycVal;
  logic [1:0][MT_W-1:0] chMtOffset;
  logic [1:0] chRunning, chFlag, chIrq;

  logic [1:0] mRun, mFlag;
  logic [MT_W-1:0] mCnt;
  int checks = 0;
  int fails = 0;
  string tag = "R3";
  bit done = 1'b0;

  cycmatch_timer u_cycmatch_timer (.*);

  function automatic bit refHit(int c);
    if (c == 1 && t2Relative) return mCnt <= 1;
    return (((cycleCount ^ chCycVal[c]) & chCycMask[c]) == '0) && (mtCount == chMtOffset[c]);
  endfunction

  task automatic modelStep();
    bit ok, ex, quiet;
    ok = (protoState == 3'd4) || (protoState == 3'd5);
    if (!rstN) begin
      mRun = '0; mFlag = '0; mCnt = '0;
      return;
    end
    for (int c = 0; c < 2; c++) begin
      quiet = !chStart[c] && !chStop[c];
      ex = mRun[c] && ok && mtStart && refHit(c) && quiet;
      if (c == 1) begin
        if (ok && !chStop[c] && (chStart[c] || (ex && chRepeat[c]))) mCnt = t2Reload;
        else if (mRun[c] && ok && mtStart && quiet) mCnt = mCnt - 1;
      end
      mFlag[c] = (mFlag[c] && !chFlagClr[c]) || ex;
      if (!ok || chStop[c]) mRun[c] = 1'b0;
      else if (chStart[c]) mRun[c] = 1'b1;
      else if (ex && !chRepeat[c]) mRun[c] = 1'b0;
    end
  endtask

  task automatic check(string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check("running", chRunning, mRun);
    check("flag", chFlag, mFlag);
    check("irq", chIrq, mFlag & chIrqEn);
    chStart = '0; chStop = '0; chFlagClr = '0;
  endtask

  task automatic tick(logic [CYC_W-1:0] cy, logic [MT_W-1:0] mt, logic st);
    cycleCount = cy; mtCount = mt; mtStart = st;
    step();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rstN = 1'b0; cycleCount = '0; mtCount = '0; mtStart = 1'b0; protoState = 3'd4;
    chStart = '0; chStop = '0; chRepeat = '0; chIrqEn = 2'b11; chFlagClr = '0;
    chCycMask = '0; chCycVal = '0; chMtOffset = '0; t2Relative = 1'b0; t2Reload = '0;
    mRun = '0; mFlag = '0; mCnt = '0;
    @(negedge clk); step(); step();
    rstN = 1'b1;
    tag = "R3"; // reset state and start/stop
    check("reset", chRunning | chFlag | chIrq, 2'b00);
    chStart = 2'b01; step();
    chStop = 2'b01; step();
    chStart = 2'b01; chStop = 2'b01; step();

    tag = "R4"; // masked cycle compare, strobe-only evaluation
    chCycMask[0] = 6'b000011; chCycVal[0] = 6'b000010; chMtOffset[0] = 14'd5;
    chRepeat[0] = 1'b1; chStart = 2'b01; step();
    tick(6'd6, 14'd5, 1'b0); tick(6'd3, 14'd5, 1'b1); tick(6'd6, 14'd4, 1'b1);
    tick(6'd6, 14'd5, 1'b1); tick(6'd42, 14'd5, 1'b1);

    tag = "R5"; // sticky flag, clear, set wins
    tick(6'd0, 14'd0, 1'b0); tick(6'd0, 14'd0, 1'b0);
    chFlagClr = 2'b01; tick(6'd0, 14'd0, 1'b0);
    chFlagClr = 2'b01; tick(6'd2, 14'd5, 1'b1);
    chFlagClr = 2'b01; tick(6'd0, 14'd0, 1'b0);

    tag = "R6"; // interrupt masking
    tick(6'd2, 14'd5, 1'b1); chIrqEn = 2'b00; tick(6'd0, 14'd0, 1'b0);
    chIrqEn = 2'b11; tick(6'd0, 14'd0, 1'b0);
    chFlagClr = 2'b11; tick(6'd0, 14'd0, 1'b0);

    tag = "R7"; // non-repeat stops after expiry
    chRepeat[0] = 1'b0; tick(6'd2, 14'd5, 1'b1); tick(6'd2, 14'd5, 1'b1);

    tag = "R1"; // leaving normal disarms, no auto-resume
    chRepeat[0] = 1'b1; chFlagClr = 2'b11; chStart = 2'b01; step();
    protoState = 3'd5; tick(6'd1, 14'd1, 1'b1);
    protoState = 3'd2; tick(6'd1, 14'd1, 1'b0);
    protoState = 3'd4; tick(6'd2, 14'd5, 1'b1); tick(6'd2, 14'd5, 1'b1);

    tag = "R2"; // start outside normal ignored
    protoState = 3'd0; chStart = 2'b11; step();
    protoState = 3'd4; tick(6'd2, 14'd5, 1'b1);

    tag = "R8"; // relative countdown
    t2Relative = 1'b1; t2Reload = 14'd3; chRepeat[1] = 1'b0; chStart = 2'b10; step();
    for (int i = 0; i < 5; i++) tick(6'd0, 14'd0, 1'b1);
    chFlagClr = 2'b10; t2Reload = 14'd0; chStart = 2'b10; step();
    tick(6'd0, 14'd0, 1'b1);
    chFlagClr = 2'b10; t2Reload = 14'd2; chRepeat[1] = 1'b1; chStart = 2'b10; step();
    for (int i = 0; i < 6; i++) tick(6'd0, 14'd0, 1'b1);

    tag = "R9"; // channel 2 absolute with own config
    chFlagClr = 2'b11; t2Relative = 1'b0; chStop = 2'b10; step();
    chCycMask[1] = 6'b111111; chCycVal[1] = 6'd9; chMtOffset[1] = 14'd7;
    chStart = 2'b11; step();
    tick(6'd2, 14'd5, 1'b1); tick(6'd9, 14'd7, 1'b1);
    t2Relative = 1'b1; tick(6'd2, 14'd5, 1'b1); t2Relative = 1'b0;

    tag = "R10"; // command in expiry cycle suppresses it
    chFlagClr = 2'b11; step();
    chStop = 2'b01; tick(6'd2, 14'd5, 1'b1);
    chStart = 2'b10; tick(6'd9, 14'd7, 1'b1);
    tick(6'd0, 14'd0, 1'b0);

    tag = "R5"; // random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      cycleCount = CYC_W'($urandom);
      mtCount = MT_W'($urandom % 4);
      mtStart = ($urandom % 3) != 0;
      protoState = ($urandom % 10 < 8) ? (3'd4 + 3'($urandom % 2)) : 3'($urandom);
      chStart = ($urandom % 6 == 0) ? 2'($urandom) : 2'b00;
      chStop = ($urandom % 15 == 0) ? 2'($urandom) : 2'b00;
      chFlagClr = ($urandom % 5 == 0) ? 2'($urandom) : 2'b00;
      if ($urandom % 50 == 0) begin
        chRepeat = 2'($urandom); chIrqEn = 2'($urandom); t2Relative = 1'($urandom);
        t2Reload = MT_W'($urandom % 5);
        for (int c = 0; c < 2; c++) begin
          chCycMask[c] = CYC_W'($urandom); chCycVal[c] = CYC_W'($urandom);
          chMtOffset[c] = MT_W'($urandom % 4);
        end
      end
      step();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule